// File: doc/BRIEF.md
# Segment Base Write Unit

This unit executes the two instructions that load the FS or the GS segment base from a general-purpose register. The unit receives an instruction that has already been split into its parts: the repeat-style mandatory prefix flag, the operand-width prefix bit, the lock prefix flag, the escape and group opcode bytes, and the ModRM byte. It also receives the current processor mode, the control-register enable bit, the feature-present bit and the value already read from the source register.

When an instruction matches, the unit runs a fixed series of checks. If every check passes, it writes the selected base register. A narrow write takes only the low 32 bits of the source and clears the upper half of the base. Any failed check raises either invalid-opcode or general-protection(0), and a faulting instruction writes neither base. The result arrives one cycle after the input pulse, as a registered done pulse that carries the fault status. The unit changes no flags.

Top module: `segbase_wr_unit`

## Requirements
- R1: An instruction matches only when all of these hold: the mandatory prefix flag is set, the escape byte is 0x0F, the opcode byte is 0xAE, and ModRM bits [7:6] are 2'b11. ModRM bits [5:3] must then be 2 to select FS or 3 to select GS. Any other input completes with no fault and changes neither base.
- R2: Each cycle with `in_valid` high produces `done` high on the next cycle, and `done` is low in all other cycles. Neither fault output is ever high while `done` is low.
- R3: A write that passes all checks with `pfx_wide` set copies all 64 bits of `src_val` into the selected base.
- R4: A write that passes all checks with `pfx_wide` clear loads `src_val[31:0]` into the low half of the selected base and zeroes the upper half. The upper half of the source has no effect on the result, and it cannot cause a general-protection fault.
- R5: A matching instruction raises `fault_ud` unless `cpu_mode` is 4, which means 64-bit mode. The other mode codes are 0 for real-address, 1 for protected, 2 for virtual-8086 and 3 for compatibility.
- R6: A matching instruction with `pfx_lock` set raises `fault_ud`.
- R7: A matching instruction raises `fault_ud` when `ctl_fsgs_en` is 0 or when `feat_present` is 0.
- R8: A matching instruction that raises no invalid-opcode fault raises `fault_gp` when the value to be written is not canonical. A value is canonical when bits [63:47] are all equal.
- R9: Invalid-opcode has priority over general-protection. The two fault outputs are never high together.
- R10: A faulting instruction leaves both bases unchanged.
- R11: While reset is held, both bases read zero and `done`, `fault_ud` and `fault_gp` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| pfx_rep | input | 1 | Mandatory prefix flag is present |
| pfx_wide | input | 1 | 64-bit operand prefix bit |
| pfx_lock | input | 1 | Lock prefix is present |
| op_esc | input | 8 | First opcode byte |
| op_byte | input | 8 | Second opcode byte |
| modrm | input | 8 | ModRM byte |
| cpu_mode | input | 3 | Processor mode code |
| ctl_fsgs_en | input | 1 | Control-register enable bit |
| feat_present | input | 1 | Feature-present bit |
| src_val | input | 64 | Source register value |
| done | output | 1 | Completion pulse |
| fault_ud | output | 1 | Invalid-opcode fault, valid with done |
| fault_gp | output | 1 | General-protection(0) fault, valid with done |
| fs_base | output | 64 | FS base register |
| gs_base | output | 64 | GS base register |

## Verification
The bound checker watches these properties on every cycle:
- the one-cycle spacing between input and done;
- that the two fault outputs never appear together, and never appear without done;
- that neither base moves during a faulting or idle cycle;
- that mode, lock and enable failures end in invalid-opcode;
- that a narrow FS write leaves the upper half at zero.

Other behaviours show up only in the bench scenarios, where a behavioural model predicts every output. These are the exact value written by a wide or narrow write, where the canonical boundary falls, that non-matching encodings are ignored, and that invalid-opcode wins over a non-canonical source.

// File: rtl/segbase_pkg.sv
// Package: shared constants and mode codes for the segment base write unit.
// Assumes the instruction has already been split into prefixes, opcode bytes and ModRM.
package segbase_pkg;
    typedef enum logic [2:0] {
        MODE_REAL   = 3'd0,
        MODE_PROT   = 3'd1,
        MODE_V86    = 3'd2,
        MODE_COMPAT = 3'd3,
        MODE_LONG   = 3'd4
    } cpu_mode_e;

    localparam logic [7:0] ESC_BYTE = 8'h0F;
    localparam logic [7:0] GRP_BYTE = 8'hAE;
    localparam logic [1:0] MOD_REG  = 2'b11;
    localparam logic [2:0] REG_FS   = 3'd2;
    localparam logic [2:0] REG_GS   = 3'd3;
    localparam int         NARROW_W = 32;
endpackage

// File: rtl/segbase_canon.sv
// Module: segbase_canon. Reports whether a value is canonical, meaning that every bit
// from DATA_W-1 down to VA_W-1 has the same value. Assumes VA_W < DATA_W.
module segbase_canon #(
    parameter int DATA_W = 64,
    parameter int VA_W   = 48
) (
    input  logic [DATA_W-1:0] val,
    output logic              is_canon
);
    localparam int TOP_W = DATA_W - VA_W + 1;

    logic [TOP_W-1:0] top_bits;

    // Compare the sign-extension region against all-ones and all-zeros.
    always_comb begin
        top_bits = val[DATA_W-1:VA_W-1];
        is_canon = (&top_bits) | ~(|top_bits);
    end
endmodule

// File: rtl/segbase_decode.sv
// Module: segbase_decode. Combinational opcode match, operand sizing and fault
// classification with a fixed priority: invalid-opcode is checked before
// general-protection. Assumes the inputs hold steady for the cycle being decoded.
module segbase_decode
    import segbase_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int VA_W   = 48
) (
    input  logic              pfx_rep,
    input  logic              pfx_wide,
    input  logic              pfx_lock,
    input  logic [7:0]        op_esc,
    input  logic [7:0]        op_byte,
    input  logic [7:0]        modrm,
    input  logic [2:0]        cpu_mode,
    input  logic              ctl_fsgs_en,
    input  logic              feat_present,
    input  logic [DATA_W-1:0] src_val,
    output logic              hit,
    output logic              sel_gs,
    output logic              bad_op,
    output logic              bad_addr,
    output logic [DATA_W-1:0] wr_val
);
    logic [1:0] mod_f;
    logic [2:0] reg_f;
    logic [2:0] unused_rm;
    logic       canon_ok;

    // Split the ModRM byte. The r/m field names the source register, which has already been read.
    always_comb begin
        mod_f     = modrm[7:6];
        reg_f     = modrm[5:3];
        unused_rm = modrm[2:0];
    end

    // Match the opcode and pick FS or GS from the reg field.
    always_comb begin
        hit    = pfx_rep && (op_esc == ESC_BYTE) && (op_byte == GRP_BYTE) &&
                 (mod_f == MOD_REG) && ((reg_f == REG_FS) || (reg_f == REG_GS));
        sel_gs = (reg_f == REG_GS);
    end

    // Size the operand: the narrow form zero-fills everything above bit NARROW_W-1.
    always_comb begin
        wr_val = src_val;
        if (!pfx_wide) begin
            wr_val = '0;
            wr_val[NARROW_W-1:0] = src_val[NARROW_W-1:0];
        end
    end

    segbase_canon #(.DATA_W(DATA_W), .VA_W(VA_W)) u_canon (
        .val      (wr_val),
        .is_canon (canon_ok)
    );

    // Classify the faults. The address check applies only when no invalid-opcode condition exists.
    always_comb begin
        bad_op   = hit && ((cpu_mode != MODE_LONG) || pfx_lock || !ctl_fsgs_en || !feat_present);
        bad_addr = hit && !bad_op && !canon_ok;
    end
endmodule

// File: rtl/segbase_bank.sv
// Module: segbase_bank. Holds the segment base registers. Entry 0 is FS and entry 1 is GS.
// Assumes at most one entry is written per cycle.
module segbase_bank #(
    parameter int DATA_W   = 64,
    parameter int NUM_SEGS = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [SEL_W-1:0]                sel,
    input  logic [DATA_W-1:0]               wdata,
    output logic [NUM_SEGS-1:0][DATA_W-1:0] bases
);
    localparam int SEL_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1;

    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
        // Base register g: cleared by reset, loaded when it is the selected write target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bases[g] <= '0;
            end else if (we && (sel == SEL_W'(g))) begin
                bases[g] <= wdata;
            end
        end
    end
endmodule

// File: rtl/segbase_wr_unit.sv
// Module: segbase_wr_unit (top). Takes one instruction per in_valid cycle. On the next
// cycle it reports done together with its fault status; a write that passes every check
// commits on the same edge. Assumes the source register has already been read.
module segbase_wr_unit #(
    parameter int DATA_W = 64,
    parameter int VA_W   = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              pfx_rep,
    input  logic              pfx_wide,
    input  logic              pfx_lock,
    input  logic [7:0]        op_esc,
    input  logic [7:0]        op_byte,
    input  logic [7:0]        modrm,
    input  logic [2:0]        cpu_mode,
    input  logic              ctl_fsgs_en,
    input  logic              feat_present,
    input  logic [DATA_W-1:0] src_val,
    output logic              done,
    output logic              fault_ud,
    output logic              fault_gp,
    output logic [DATA_W-1:0] fs_base,
    output logic [DATA_W-1:0] gs_base
);
    localparam int NUM_SEGS = 2;

    logic                            hit, sel_gs, bad_op, bad_addr, commit;
    logic [DATA_W-1:0]               wr_val;
    logic [NUM_SEGS-1:0][DATA_W-1:0] bank_q;

    segbase_decode #(.DATA_W(DATA_W), .VA_W(VA_W)) u_dec (
        .pfx_rep      (pfx_rep),
        .pfx_wide     (pfx_wide),
        .pfx_lock     (pfx_lock),
        .op_esc       (op_esc),
        .op_byte      (op_byte),
        .modrm        (modrm),
        .cpu_mode     (cpu_mode),
        .ctl_fsgs_en  (ctl_fsgs_en),
        .feat_present (feat_present),
        .src_val      (src_val),
        .hit          (hit),
        .sel_gs       (sel_gs),
        .bad_op       (bad_op),
        .bad_addr     (bad_addr),
        .wr_val       (wr_val)
    );

    // Commit only a matched instruction that raised no fault.
    always_comb commit = in_valid && hit && !bad_op && !bad_addr;

    segbase_bank #(.DATA_W(DATA_W), .NUM_SEGS(NUM_SEGS)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit),
        .sel   (sel_gs),
        .wdata (wr_val),
        .bases (bank_q)
    );

    // Register the completion pulse and the fault status one cycle after the input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            fault_ud <= 1'b0;
            fault_gp <= 1'b0;
        end else begin
            done     <= in_valid;
            fault_ud <= in_valid && bad_op;
            fault_gp <= in_valid && bad_addr;
        end
    end

    // Expose the bank entries as the named base outputs.
    always_comb begin
        fs_base = bank_q[0];
        gs_base = bank_q[1];
    end
endmodule

// File: rtl/segbase_wr_unit_chk.sv
// Module: segbase_wr_unit_chk. Holds the properties of the segment base write unit and
// is bound to the top module. It observes ports only.
module segbase_wr_unit_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              pfx_rep,
    input logic              pfx_wide,
    input logic              pfx_lock,
    input logic [7:0]        op_esc,
    input logic [7:0]        op_byte,
    input logic [7:0]        modrm,
    input logic [2:0]        cpu_mode,
    input logic              ctl_fsgs_en,
    input logic              feat_present,
    input logic [DATA_W-1:0] src_val,
    input logic              done,
    input logic              fault_ud,
    input logic              fault_gp,
    input logic [DATA_W-1:0] fs_base,
    input logic [DATA_W-1:0] gs_base
);
    logic cand, legal, any_fault, unused_src;

    // True for an accepted encoding, and for an encoding that also passes every enable check.
    always_comb begin
        cand       = in_valid && pfx_rep && op_esc == 8'h0F && op_byte == 8'hAE &&
                     modrm[7:6] == 2'b11 && (modrm[5:3] == 3'd2 || modrm[5:3] == 3'd3);
        legal      = cand && cpu_mode == 3'd4 && !pfx_lock && ctl_fsgs_en && feat_present;
        any_fault  = fault_ud || fault_gp;
        unused_src = ^src_val;
    end

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);
    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done);
    p_fault_with_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        any_fault |-> done);
    p_single_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_ud && fault_gp));
    p_ud_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cand && cpu_mode != 3'd4) |=> fault_ud);
    p_ud_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cand && pfx_lock) |=> fault_ud);
    p_ud_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cand && (!ctl_fsgs_en || !feat_present)) |=> fault_ud);
    p_narrow_fs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (legal && !pfx_wide && modrm[5:3] == 3'd2) |=>
            (fs_base[DATA_W-1:32] == '0 && !fault_gp));
    p_hold_on_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        any_fault |-> ($stable(fs_base) && $stable(gs_base)));
    p_change_needs_commit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(fs_base) || !$stable(gs_base)) |-> (done && !any_fault));
endmodule

bind segbase_wr_unit segbase_wr_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/segbase_wr_unit_test.sv
// Bench: drives scenarios into segbase_wr_unit and compares every output on every
// cycle against a behavioural model that is kept in the bench.
`timescale 1ns/1ps
module segbase_wr_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        pfx_rep = 1'b0, pfx_wide = 1'b0, pfx_lock = 1'b0;
    logic [7:0]  op_esc = 8'h00, op_byte = 8'h00, modrm = 8'h00;
    logic [2:0]  cpu_mode = 3'd0;
    logic        ctl_fsgs_en = 1'b0, feat_present = 1'b0;
    logic [63:0] src_val = 64'h0;
    logic        done, fault_ud, fault_gp;
    logic [63:0] fs_base, gs_base;

    int    total = 0;
    int    bad = 0;
    bit    chk_on = 0;
    string tag = "R11";

    // Model state.
    bit          m_done = 0, m_ud = 0, m_gp = 0;
    logic [63:0] m_fs = 64'h0, m_gs = 64'h0;

    always #2.5 clk = ~clk;

    segbase_wr_unit uut (.*);

    // Outcome codes: 0 = no match, 1 = write, 2 = invalid-opcode, 3 = general-protection.
    function automatic int classify(output logic [63:0] val);
        longint s;
        bit     hit;
        hit = pfx_rep && op_esc == 8'h0F && op_byte == 8'hAE && modrm[7:6] == 2'b11 &&
              (modrm[5:3] == 3'd2 || modrm[5:3] == 3'd3);
        val = pfx_wide ? src_val : {32'h0, src_val[31:0]};
        if (!hit) return 0;
        if (cpu_mode != 3'd4 || pfx_lock || !ctl_fsgs_en || !feat_present) return 2;
        s = val;
        s = s >>> 47;
        if (s != 0 && s != -1) return 3;
        return 1;
    endfunction

    // Model update on each rising edge.
    always @(posedge clk) begin
        logic [63:0] v;
        int          k;
        if (!rst_n) begin
            m_done = 0; m_ud = 0; m_gp = 0; m_fs = 0; m_gs = 0;
        end else begin
            m_done = in_valid; m_ud = 0; m_gp = 0;
            if (in_valid) begin
                k = classify(v);
                m_ud = (k == 2);
                m_gp = (k == 3);
                if (k == 1) begin
                    if (modrm[5:3] == 3'd3) m_gs = v; else m_fs = v;
                end
            end
        end
    end

    task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // Compare every output 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        if (chk_on) begin
            chk("R2", "done", 64'(done), 64'(m_done));
            chk(tag, "fault_ud", 64'(fault_ud), 64'(m_ud));
            chk(tag, "fault_gp", 64'(fault_gp), 64'(m_gp));
            chk(tag, "fs_base", fs_base, m_fs);
            chk(tag, "gs_base", gs_base, m_gs);
        end
    end

    // Drive one instruction for one cycle. Call idle() afterwards to drop in_valid.
    task automatic issue(string t, logic [63:0] src, logic [2:0] regf = 3'd2,
                         bit wide = 1, int mode = 4, bit lock = 0, bit en = 1,
                         bit feat = 1, bit rep = 1, logic [7:0] esc = 8'h0F,
                         logic [7:0] grp = 8'hAE, logic [1:0] md = 2'b11);
        @(negedge clk);
        tag = t;
        in_valid = 1; pfx_rep = rep; pfx_wide = wide; pfx_lock = lock;
        op_esc = esc; op_byte = grp; modrm = {md, regf, 3'd5};
        cpu_mode = mode[2:0]; ctl_fsgs_en = en; feat_present = feat; src_val = src;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 0;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        chk_on = 1;
        repeat (2) @(negedge clk);
        chk("R11", "reset fs", fs_base, 64'h0);
        chk("R11", "reset gs", gs_base, 64'h0);
        chk("R11", "reset done", 64'(done), 64'h0);
        @(negedge clk); rst_n = 1;
        // Wide writes (R3).
        issue("R3", 64'h0000_7fff_dead_beef, 3'd2); idle();
        issue("R3", 64'hffff_8000_0000_1234, 3'd3); idle();
        // Narrow writes ignore the upper half (R4).
        issue("R4", 64'habcd_ef01_2345_6789, 3'd2, 0); idle();
        issue("R4", 64'h8000_0000_ffff_fff0, 3'd3, 0); idle();
        // Non-matching encodings (R1).
        issue("R1", 64'h1, 3'd2, 1, 4, 0, 1, 1, 0); idle();
        issue("R1", 64'h2, 3'd2, 1, 4, 0, 1, 1, 1, 8'h0F, 8'hAF); idle();
        issue("R1", 64'h3, 3'd2, 1, 4, 0, 1, 1, 1, 8'h0E); idle();
        issue("R1", 64'h4, 3'd3, 1, 4, 0, 1, 1, 1, 8'h0F, 8'hAE, 2'b00); idle();
        issue("R1", 64'h5, 3'd1); idle();
        issue("R1", 64'h6, 3'd4); idle();
        // Every mode other than 64-bit (R5).
        for (int m = 0; m < 4; m++) begin
            issue("R5", 64'h77, 3'd2, 1, m); idle();
        end
        // Lock prefix (R6).
        issue("R6", 64'h99, 3'd3, 1, 4, 1); idle();
        // Enable and feature bits (R7).
        issue("R7", 64'haa, 3'd2, 1, 4, 0, 0); idle();
        issue("R7", 64'hbb, 3'd3, 0, 4, 0, 1, 0); idle();
        // Canonical boundary (R8) with bases held (R10).
        issue("R8", 64'h0000_8000_0000_0000, 3'd2); idle();
        issue("R8", 64'hfffe_ffff_ffff_ffff, 3'd3); idle();
        issue("R10", 64'h7fff_0000_0000_0000, 3'd3); idle();
        issue("R8", 64'hffff_8000_0000_0000, 3'd2); idle();
        // Invalid-opcode wins over a non-canonical source (R9).
        issue("R9", 64'h1234_0000_0000_0000, 3'd2, 1, 4, 1); idle();
        issue("R9", 64'h1234_0000_0000_0000, 3'd3, 1, 2); idle();
        // Back-to-back instructions (R2).
        issue("R2", 64'h11, 3'd2);
        issue("R2", 64'h22, 3'd3, 0);
        issue("R2", 64'h33, 3'd2, 1, 4, 1);
        issue("R2", 64'h44, 3'd3);
        idle();
        repeat (3) @(negedge clk);
        // Reset clears the state again (R11).
        tag = "R11";
        rst_n = 0;
        repeat (2) @(negedge clk);
        chk("R11", "reset fs again", fs_base, 64'h0);
        chk("R11", "reset gs again", gs_base, 64'h0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule